// File: doc/BRIEF.md
# Programmable Timer / Event Counter with Single-Shot Pulse Capture

This peripheral holds an 8-bit up-counter with a separate reload register. It counts from its present value up to 0xFF. On the next count after 0xFF it loads the reload value again and raises a sticky interrupt flag. Each wrap also toggles a square-wave output, so that output runs at the tick rate divided by 2×(256−N), where N is the reload value.

The count source depends on the mode:
- **Stopped:** nothing counts.
- **Event count:** rising edges of an external pin, after a two-stage synchroniser.
- **Timer:** an internal clock-enable tick.
- **Pulse-width:** internal ticks, counted only while the external pin holds one level.

In pulse-width mode the block waits for a chosen start edge. It counts ticks while the pin stays at the new level. When the pin returns, it clears its own enable bit. The result then stays in the counter, untouched by later edges, until software arms it again.

Software sees two locations. Address 0 is a write-only reload register, and a read of the same address returns the live counter. Address 1 is the control register.

Top module: `evtTimer`

## Requirements
- R1: After reset the counter reads 0x00, the control register reads 0x00, and both `irq` and `pfdOut` are 0.
- R2: A write to address 0 changes only the reload register. A read of address 0 returns the live counter, which the write leaves unchanged.
- R3: In timer mode (control bits [3:2] = 2'b10) with enable (bit 0) set, the counter steps by one on each clock where `tickEn` is 1. Activity on `extIn` has no effect in this mode.
- R4: In event mode (bits [3:2] = 2'b01) with enable set, the counter steps once per rising edge of `extIn`. The step shows three clocks after the edge. `tickEn` has no effect in this mode.
- R5: A step taken from 0xFF loads the reload value, and `irq` goes to 1 on that same clock edge.
- R6: `irq` (control bit 4) stays at 1 until software writes the control register with bit 4 equal to 0.
- R7: `pfdOut` toggles on every wrap and at no other time.
- R8: A control write that sets enable while enable is 0 copies the reload value into the counter. Counting starts with later ticks or edges.
- R9: In pulse-width mode (bits [3:2] = 2'b11), bit 1 selects the start edge: 1 for rising, 0 for falling. From the start edge onward, the block counts one per tick for every clock that the synchronised pin stays at the new level.
- R10: When the pin returns to its original level, the enable bit reads 0. The count is held, and a further start edge leaves it unchanged.
- R11: With enable at 0, or with mode bits at 2'b00, the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Internal count tick (clock enable) |
| extIn | input | 1 | External event / pulse pin, asynchronous |
| regAddr | input | 1 | 0 = reload/counter, 1 = control |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read enable; read data is 0 when low |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data |
| irq | output | 1 | Sticky interrupt-request flag |
| pfdOut | output | 1 | Square wave, toggled on each wrap |

## Verification
The bench times wraps tick by tick from 0xFC. A design that reloaded one step early or late, or that set the flag a clock away from the reload, would show the wrong count or flag value at the sampled edge.

In pulse mode the bench applies pulses of known length with both edge polarities. It then sends a second pulse after completion. This catches:
- a count off by one at the start edge;
- an enable that never clears;
- a block that re-arms and measures again.

It also writes the reload register while the counter is running. This exposes a design that sends writes into the live counter. Finally, it toggles the unused source in each mode to show that it is ignored.

// File: rtl/evtTimerPkg.sv
package evtTimerPkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EVT = 2'b01,
    MODE_TMR = 2'b10,
    MODE_PW  = 2'b11
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic stepCnt;   // advance counter (or reload on wrap)
    logic loadCnt;   // copy reload value into counter (arming)
  } strobeT;

  localparam int CTRL_BITS = 5;
endpackage

// File: rtl/evtTimerCtrl.sv
module evtTimerCtrl
  import evtTimerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 extIn,
  input  logic                 ctrlWr,
  input  logic [CTRL_BITS-1:0] ctrlWrData,
  input  logic                 ovf,
  output strobeT               strb,
  output logic [CTRL_BITS-1:0] ctrlView,
  output logic                 irqFlag
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic levelPrev;
  logic level, rise, fall;
  logic en, edgeSel, measuring;
  modeT mode;
  logic pwActive, startEdge, holdLevel, pwEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      levelPrev <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_STAGES-2:0], extIn};
      levelPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign level = syncQ[SYNC_STAGES-1];
  assign rise  = level & ~levelPrev;
  assign fall  = ~level & levelPrev;

  assign pwActive  = en && (mode == MODE_PW);
  assign startEdge = pwActive && !measuring && (edgeSel ? rise : fall);
  assign holdLevel = pwActive && measuring && (level == edgeSel);
  assign pwEnd     = pwActive && measuring && (level != edgeSel);

  always_comb begin
    strb.stepCnt = 1'b0;
    unique case (mode)
      MODE_EVT: strb.stepCnt = en && rise;
      MODE_TMR: strb.stepCnt = en && tickEn;
      MODE_PW:  strb.stepCnt = (startEdge || holdLevel) && tickEn;
      default:  strb.stepCnt = 1'b0;
    endcase
    strb.loadCnt = ctrlWr && ctrlWrData[0] && !en;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en        <= 1'b0;
      edgeSel   <= 1'b0;
      mode      <= MODE_OFF;
      irqFlag   <= 1'b0;
      measuring <= 1'b0;
    end else begin
      if (ctrlWr) begin
        en      <= ctrlWrData[0];
        edgeSel <= ctrlWrData[1];
        mode    <= modeT'(ctrlWrData[3:2]);
        irqFlag <= ctrlWrData[4] | ovf;
      end else begin
        if (pwEnd) en <= 1'b0;
        if (ovf) irqFlag <= 1'b1;
      end
      if (!pwActive || pwEnd) measuring <= 1'b0;
      else if (startEdge)     measuring <= 1'b1;
    end
  end

  assign ctrlView = {irqFlag, mode, edgeSel, en};

  // R5: a wrap always leaves the flag raised
  a_r5_irq_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> irqFlag);
  // R6: flag is sticky without a control write
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !ctrlWr) |=> irqFlag);
  // R10: return to original level drops enable
  a_r10_pw_self_stop: assert property (@(posedge clk) disable iff (!rstN)
    (pwEnd && !ctrlWr) |=> !en);
  // R10: after self-stop nothing counts until re-armed
  a_r10_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !ctrlWr) |=> !strb.stepCnt);
endmodule

// File: rtl/evtTimerDp.sv
module evtTimerDp
  import evtTimerPkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  input  logic          preWr,
  input  logic [DW-1:0] preData,
  output logic [DW-1:0] cnt,
  output logic          ovf,
  output logic          pfd
);
  localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};

  logic [DW-1:0] preload;

  assign ovf = strb.stepCnt && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preload <= '0;
      cnt     <= '0;
      pfd     <= 1'b0;
    end else begin
      if (preWr) preload <= preData;
      if (strb.loadCnt)      cnt <= preload;
      else if (strb.stepCnt) cnt <= ovf ? preload : cnt + 1'b1;
      if (ovf) pfd <= ~pfd;
    end
  end

  // R5: wrap reloads the value held before the edge
  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> cnt == $past(preload));
  // R7: square wave moves only on a wrap
  a_r7_pfd_wrap_only: assert property (@(posedge clk) disable iff (!rstN)
    !ovf |=> $stable(pfd));
  // R11: counter holds without a strobe
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepCnt && !strb.loadCnt) |=> $stable(cnt));
  // R2: load and step never collide
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadCnt && strb.stepCnt));
endmodule

// File: rtl/evtTimer.sv
module evtTimer
  import evtTimerPkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          extIn,
  input  logic          regAddr,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  output logic          irq,
  output logic          pfdOut
);
  strobeT               strb;
  logic [DW-1:0]        cnt;
  logic                 ovf;
  logic [CTRL_BITS-1:0] ctrlView;

  evtTimerCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn(extIn),
    .ctrlWr(regWr && regAddr), .ctrlWrData(regWrData[CTRL_BITS-1:0]),
    .ovf(ovf), .strb(strb), .ctrlView(ctrlView), .irqFlag(irq)
  );

  evtTimerDp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .preWr(regWr && !regAddr), .preData(regWrData),
    .cnt(cnt), .ovf(ovf), .pfd(pfdOut)
  );

  always_comb begin
    if (!regRd)       regRdData = '0;
    else if (regAddr) regRdData = {{(DW-CTRL_BITS){1'b0}}, ctrlView};
    else              regRdData = cnt;
  end
endmodule

// File: tb/evtTimer_tb.sv
module evtTimer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, extIn = 1'b0, regAddr = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irq, pfdOut;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  evtTimer u_dut (.clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn(extIn),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .pfdOut(pfdOut));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWr = 1'b1; regWrData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(logic a, output logic [7:0] d);
    regAddr = a; regRd = 1'b1; #1; d = regRdData; regRd = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    rdReg(1'b0, v); chk("R1 counter", v, 8'h00);
    rdReg(1'b1, v); chk("R1 control", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 pfd", {7'b0, pfdOut}, 8'h00);
  endtask

  task automatic testTimer();
    logic [7:0] v;
    wrReg(1'b0, 8'hFC);
    wrReg(1'b1, 8'h09);
    rdReg(1'b0, v); chk("R8 arm copies reload", v, 8'hFC);
    ticks(3);
    rdReg(1'b0, v); chk("R3 timer steps", v, 8'hFF);
    chk("R5 no irq before wrap", {7'b0, irq}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); extIn = ~extIn;
      @(negedge clk);
    end
    extIn = 1'b0; idle(4);
    rdReg(1'b0, v); chk("R3 extIn ignored in timer", v, 8'hFF);
    ticks(1);
    rdReg(1'b0, v); chk("R5 wrap reloads", v, 8'hFC);
    chk("R5 irq on wrap", {7'b0, irq}, 8'h01);
    chk("R7 pfd toggled", {7'b0, pfdOut}, 8'h01);
    wrReg(1'b0, 8'h10);
    rdReg(1'b0, v); chk("R2 reload write leaves counter", v, 8'hFC);
    idle(5);
    chk("R6 irq sticky", {7'b0, irq}, 8'h01);
    rdReg(1'b1, v); chk("R6 irq in control bit4", v, 8'h19);
    wrReg(1'b1, 8'h09);
    chk("R6 irq cleared by write", {7'b0, irq}, 8'h00);
    ticks(3);
    chk("R7 pfd steady between wraps", {7'b0, pfdOut}, 8'h01);
    ticks(1);
    rdReg(1'b0, v); chk("R5 second wrap uses new reload", v, 8'h10);
    chk("R7 pfd toggles back", {7'b0, pfdOut}, 8'h00);
  endtask

  task automatic testStopped();
    logic [7:0] v;
    wrReg(1'b1, 8'h00);
    wrReg(1'b1, 8'h01);
    ticks(3);
    rdReg(1'b0, v); chk("R11 mode off no count", v, 8'h10);
    wrReg(1'b1, 8'h08);
    ticks(3);
    rdReg(1'b0, v); chk("R11 enable low no count", v, 8'h10);
  endtask

  task automatic testEvent();
    logic [7:0] v;
    wrReg(1'b1, 8'h00);
    wrReg(1'b0, 8'h20);
    wrReg(1'b1, 8'h05);
    @(negedge clk); tickEn = 1'b1; idle(6); tickEn = 1'b0;
    rdReg(1'b0, v); chk("R4 tickEn ignored in event", v, 8'h20);
    for (int i = 0; i < 3; i++) begin
      extIn = 1'b1; idle(3);
      extIn = 1'b0; idle(3);
    end
    idle(4);
    rdReg(1'b0, v); chk("R4 three rising edges", v, 8'h23);
  endtask

  task automatic testPulse();
    logic [7:0] v;
    wrReg(1'b1, 8'h00);
    wrReg(1'b0, 8'h00);
    extIn = 1'b0; tickEn = 1'b1; idle(4);
    wrReg(1'b1, 8'h0F);
    idle(3);
    rdReg(1'b0, v); chk("R9 idle before start edge", v, 8'h00);
    extIn = 1'b1; idle(5);
    extIn = 1'b0; idle(6);
    rdReg(1'b0, v); chk("R9 high pulse width", v, 8'h05);
    rdReg(1'b1, v); chk("R10 enable self-cleared", v, 8'h0E);
    extIn = 1'b1; idle(3);
    extIn = 1'b0; idle(6);
    rdReg(1'b0, v); chk("R10 result held", v, 8'h05);
    wrReg(1'b1, 8'h00);
    extIn = 1'b1; idle(5);
    wrReg(1'b1, 8'h0D);
    rdReg(1'b0, v); chk("R8 re-arm copies reload", v, 8'h00);
    extIn = 1'b0; idle(3);
    extIn = 1'b1; idle(6);
    rdReg(1'b0, v); chk("R9 low pulse width", v, 8'h03);
    rdReg(1'b1, v); chk("R10 enable cleared falling", v, 8'h0C);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTimer();
    testStopped();
    testEvent();
    testPulse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule